// File: doc/BRIEF.md
# Single-to-Half Precision Converter

This block turns a 32-bit binary floating-point operand into a 16-bit half-precision value in one clock. It rounds according to a selectable mode, saturates on overflow, builds subnormal results when the value falls below the normal half range, and reports four exception flags. A format select picks standard IEEE half precision or an extended-range half format. The extended format gives up the infinity and NaN codes, so exponent field 31 holds ordinary finite numbers.

The operand and all controls are sampled on a rising clock edge. The result and flags appear on the outputs after that edge and are held until the next edge. Synchronous active-high reset clears the outputs. Tininess for the underflow flag can be judged before or after rounding. A separate control flushes single-precision denormal inputs to a signed zero.

Top module: `f2h_convert`

## Requirements
- R1: While reset is high at a clock edge, the result and all four flags are zero after that edge. Otherwise the outputs after an edge reflect the inputs sampled at that edge (one cycle of latency).
- R2: A finite operand in the normal half range whose low 13 fraction bits are zero converts exactly. It keeps its sign, the exponent is rebiased from 127 to 15, and the fraction is truncated to its top 10 bits. No flag is raised.
- R3: Rounding mode code 0 rounds to nearest. An exact tie rounds up only when the retained least significant bit is 1. Inexact is raised whenever any dropped bit is nonzero.
- R4: Mode code 1 rounds toward +infinity, code 2 rounds toward -infinity, and code 3 truncates. Each directed mode moves the magnitude up only for the sign it points at.
- R5: When rounding carries the 11-bit significand out of range, the exponent field increases by one and the fraction becomes zero.
- R6: With the format select at 0, any finite value whose rounded exponent field would exceed 30 gives signed infinity (field 31, fraction 0). This applies in every rounding mode and raises overflow and inexact.
- R7: With the format select at 1, exponent field 31 is a normal finite exponent. A value that would exceed field 31 gives the signed maximum magnitude (low 15 bits all ones) and raises invalid only.
- R8: A value below 2^-14 gives a subnormal result. It is rounded at subnormal precision in the selected mode. A value that cannot reach the smallest subnormal gives signed zero, unless a directed mode rounds it up to the smallest subnormal.
- R9: Underflow is raised only for a tiny, inexact result. With the tininess select at 1, tiny means the value is below 2^-14. With it at 0, tiny also requires that the rounded result stays below 2^-14.
- R10: A denormal operand (exponent 0, fraction nonzero) gives signed zero with no flags when the flush enable is 1. Otherwise it is treated as a tiny value.
- R11: A zero operand gives a zero of the same sign with no flags.
- R12: With the format select at 0, infinity maps to signed infinity with no flags. A NaN gives sign, field 31, fraction bit 9 set, and fraction bits 8..0 taken from operand fraction bits 21..13. Invalid is raised only when operand fraction bit 22 is 0 (a signaling NaN).
- R13: With the format select at 1, a NaN operand gives signed zero and an infinite operand gives the signed maximum magnitude. Both raise invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Single-precision operand |
| rnd_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward +inf, 2 toward -inf, 3 toward zero |
| tin_before_i | input | 1 | 1: tininess judged before rounding; 0: after rounding |
| flush_den_i | input | 1 | 1: denormal operands become signed zero |
| alt_fmt_i | input | 1 | 0: IEEE half; 1: extended-range half without infinity or NaN |
| dst_o | output | 16 | Half-precision result |
| flag_inexact_o | output | 1 | Result differs from the operand value |
| flag_underflow_o | output | 1 | Tiny and inexact result |
| flag_overflow_o | output | 1 | IEEE-format overflow to infinity |
| flag_invalid_o | output | 1 | Signaling NaN, or an unrepresentable value in the extended format |

## Verification
The bench aims at the points where the rounding precision or the exponent changes. It covers ties at normal and subnormal precision, values just below 2^-14 that round into the normal range, values just under 2^-25, and the largest finite values of both formats. A wrong mask width would round subnormals at normal precision and miss the smallest subnormal. A wrong tininess rule would raise underflow on results that reach 2^-14. An off-by-one maximum exponent would overflow 65536 in the extended format or let 65520 through in IEEE format. The special-value cases catch a design that leaks NaN codes into the extended format or treats quiet NaNs as invalid.

// File: rtl/f2h_pkg.sv
`timescale 1ns/1ps
package f2h_pkg;
    localparam int SP_EXP_W    = 8;
    localparam int SP_FRAC_W   = 23;
    localparam int HP_EXP_W    = 5;
    localparam int HP_FRAC_W   = 10;
    localparam int SP_W        = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int HP_W        = 1 + HP_EXP_W + HP_FRAC_W;
    localparam int SP_BIAS     = 2 ** (SP_EXP_W - 1) - 1;
    localparam int HP_BIAS     = 2 ** (HP_EXP_W - 1) - 1;
    localparam int SIG_W       = SP_FRAC_W + 1;
    localparam int DROP_N      = SP_FRAC_W - HP_FRAC_W;
    localparam int KEEP_W      = HP_FRAC_W + 1;
    localparam int WORK_W      = SIG_W + 2;
    localparam int MAX_SH      = SIG_W + 1;
    localparam int SH_W        = $clog2(WORK_W);
    localparam int EXP_W       = SP_EXP_W + 2;
    localparam int EXP_OFS     = SP_BIAS - HP_BIAS;
    localparam int HP_EXP_ALL  = 2 ** HP_EXP_W - 1;
    localparam int NAN_KEEP    = HP_FRAC_W - 1;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_UP      = 2'd1,
        RM_DOWN    = 2'd2,
        RM_ZERO    = 2'd3
    } rnd_mode_e;

    typedef enum logic [2:0] {
        CLS_ZERO, CLS_FIN, CLS_INF, CLS_QNAN, CLS_SNAN
    } cls_e;

    typedef struct packed {
        logic                    sign;
        cls_e                    cls;
        logic signed [EXP_W-1:0] hexp;
        logic [SIG_W-1:0]        sig;
        logic [NAN_KEEP-1:0]     nan_top;
    } operand_t;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic invalid;
    } fpflags_t;

    function automatic logic round_inc(input rnd_mode_e m, input logic sgn,
                                       input logic lsb, input logic gt,
                                       input logic tie, input logic nz);
        case (m)
            RM_NEAREST: return gt | (tie & lsb);
            RM_UP:      return ~sgn & nz;
            RM_DOWN:    return sgn & nz;
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/f2h_classify.sv
`timescale 1ns/1ps
module f2h_classify
    import f2h_pkg::*;
(
    input  logic [SP_W-1:0] operand,
    input  logic            flush_den,
    output operand_t        opd
);
    localparam logic signed [EXP_W-1:0] OFS_S = EXP_W'(EXP_OFS);

    logic [SP_EXP_W-1:0]  exp_f;
    logic [SP_FRAC_W-1:0] frac_f;
    logic [SP_EXP_W-1:0]  eff_exp;

    assign exp_f  = operand[SP_W-2 -: SP_EXP_W];
    assign frac_f = operand[SP_FRAC_W-1:0];

    always_comb begin
        eff_exp     = (exp_f == '0) ? SP_EXP_W'(1) : exp_f;
        opd.sign    = operand[SP_W-1];
        opd.sig     = {exp_f != '0, frac_f};
        opd.hexp    = $signed({2'b00, eff_exp}) - OFS_S;
        opd.nan_top = frac_f[SP_FRAC_W-2 -: NAN_KEEP];
        if (exp_f == '1) begin
            if (frac_f == '0)               opd.cls = CLS_INF;
            else if (frac_f[SP_FRAC_W-1])   opd.cls = CLS_QNAN;
            else                            opd.cls = CLS_SNAN;
        end else if (exp_f == '0 && (frac_f == '0 || flush_den)) begin
            opd.cls = CLS_ZERO;
        end else begin
            opd.cls = CLS_FIN;
        end
    end
endmodule

// File: rtl/f2h_round.sv
`timescale 1ns/1ps
module f2h_round
    import f2h_pkg::*;
(
    input  logic                    sign,
    input  logic signed [EXP_W-1:0] hexp,
    input  logic [SIG_W-1:0]        sig,
    input  rnd_mode_e               mode,
    input  logic                    tin_before,
    input  logic                    alt_fmt,
    output logic [HP_W-1:0]         res,
    output fpflags_t                flg
);
    localparam logic signed [EXP_W-1:0] E_ZERO   = '0;
    localparam logic signed [EXP_W-1:0] E_ONE    = EXP_W'(1);
    localparam logic signed [EXP_W-1:0] SUB_BASE = EXP_W'(DROP_N + 1);
    localparam logic signed [EXP_W-1:0] SH_CAP   = EXP_W'(MAX_SH);
    localparam logic signed [EXP_W-1:0] MAXE_STD = EXP_W'(HP_EXP_ALL - 1);
    localparam logic signed [EXP_W-1:0] MAXE_ALT = EXP_W'(HP_EXP_ALL);

    logic                    is_sub, gt, tie, nz, inc, ovf, tiny;
    logic signed [EXP_W-1:0] sh_full, em1, max_e;
    logic [SH_W-1:0]         sh;
    logic [WORK_W-1:0]       work, mask_v, low, half_v;
    logic [KEEP_W-1:0]       kept;
    logic [HP_EXP_W-1:0]     field_lo;
    logic [HP_EXP_W:0]       max_f;
    logic [HP_W-1:0]         base, sum;

    always_comb begin
        is_sub  = (hexp <= E_ZERO);
        sh_full = SUB_BASE - hexp;
        if (!is_sub)              sh = SH_W'(DROP_N);
        else if (sh_full > SH_CAP) sh = SH_W'(MAX_SH);
        else                       sh = sh_full[SH_W-1:0];

        // split the significand into kept bits and dropped bits
        work   = WORK_W'(sig);
        mask_v = (WORK_W'(1) << sh) - WORK_W'(1);
        low    = work & mask_v;
        half_v = WORK_W'(1) << (sh - SH_W'(1));
        kept   = KEEP_W'(work >> sh);
        nz     = |low;
        gt     = low > half_v;
        tie    = low == half_v;
        inc    = round_inc(mode, sign, kept[0], gt, tie, nz);

        // hidden bit of a normal value adds the missing one to field_lo
        em1      = hexp - E_ONE;
        field_lo = is_sub ? '0 : em1[HP_EXP_W-1:0];
        base     = {1'b0, field_lo, {HP_FRAC_W{1'b0}}} + HP_W'(kept);
        sum      = base + HP_W'(inc);

        max_e = alt_fmt ? MAXE_ALT : MAXE_STD;
        max_f = alt_fmt ? (HP_EXP_W+1)'(HP_EXP_ALL) : (HP_EXP_W+1)'(HP_EXP_ALL - 1);
        ovf   = (hexp > max_e) || (sum[HP_W-1:HP_FRAC_W] > max_f);
        tiny  = is_sub && (tin_before || sum[HP_W-2:HP_FRAC_W] == '0);

        flg = '0;
        if (ovf) begin
            if (alt_fmt) begin
                res         = {sign, {(HP_W-1){1'b1}}};
                flg.invalid = 1'b1;
            end else begin
                res          = {sign, {HP_EXP_W{1'b1}}, {HP_FRAC_W{1'b0}}};
                flg.overflow = 1'b1;
                flg.inexact  = 1'b1;
            end
        end else begin
            res           = {sign, sum[HP_W-2:0]};
            flg.inexact   = nz;
            flg.underflow = nz & tiny;
        end
    end
endmodule

// File: rtl/f2h_convert.sv
`timescale 1ns/1ps
module f2h_convert
    import f2h_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] src_i,
    input  logic [1:0]  rnd_i,
    input  logic        tin_before_i,
    input  logic        flush_den_i,
    input  logic        alt_fmt_i,
    output logic [15:0] dst_o,
    output logic        flag_inexact_o,
    output logic        flag_underflow_o,
    output logic        flag_overflow_o,
    output logic        flag_invalid_o
);
    operand_t         opd;
    logic [HP_W-1:0]  rnd_res, nxt_res, dst_q;
    fpflags_t         rnd_flg, nxt_flg, flg_q;

    f2h_classify u_cls (
        .operand   (src_i),
        .flush_den (flush_den_i),
        .opd       (opd)
    );

    f2h_round u_rnd (
        .sign       (opd.sign),
        .hexp       (opd.hexp),
        .sig        (opd.sig),
        .mode       (rnd_mode_e'(rnd_i)),
        .tin_before (tin_before_i),
        .alt_fmt    (alt_fmt_i),
        .res        (rnd_res),
        .flg        (rnd_flg)
    );

    always_comb begin
        nxt_res = rnd_res;
        nxt_flg = rnd_flg;
        case (opd.cls)
            CLS_ZERO: begin
                nxt_res = {opd.sign, {(HP_W-1){1'b0}}};
                nxt_flg = '0;
            end
            CLS_INF: begin
                nxt_flg = '0;
                if (alt_fmt_i) begin
                    nxt_res         = {opd.sign, {(HP_W-1){1'b1}}};
                    nxt_flg.invalid = 1'b1;
                end else begin
                    nxt_res = {opd.sign, {HP_EXP_W{1'b1}}, {HP_FRAC_W{1'b0}}};
                end
            end
            CLS_QNAN, CLS_SNAN: begin
                nxt_flg         = '0;
                nxt_flg.invalid = alt_fmt_i || (opd.cls == CLS_SNAN);
                if (alt_fmt_i) nxt_res = {opd.sign, {(HP_W-1){1'b0}}};
                else           nxt_res = {opd.sign, {HP_EXP_W{1'b1}}, 1'b1, opd.nan_top};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q <= '0;
            flg_q <= '0;
        end else begin
            dst_q <= nxt_res;
            flg_q <= nxt_flg;
        end
    end

    assign dst_o            = dst_q;
    assign flag_inexact_o   = flg_q.inexact;
    assign flag_underflow_o = flg_q.underflow;
    assign flag_overflow_o  = flg_q.overflow;
    assign flag_invalid_o   = flg_q.invalid;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dst_o == '0 && !flag_inexact_o && !flag_underflow_o
                 && !flag_overflow_o && !flag_invalid_o));

    assert_ovf_gives_inf_R6: assert property (@(posedge clk) disable iff (rst)
        flag_overflow_o |-> (dst_o[14:0] == 15'h7c00 && flag_inexact_o));

    assert_alt_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(alt_fmt_i)) |-> !flag_overflow_o);

    assert_underflow_inexact_R9: assert property (@(posedge clk) disable iff (rst)
        flag_underflow_o |-> flag_inexact_o);

    assert_zero_in_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(src_i[30:0]) == 31'd0) |->
        (dst_o[14:0] == 15'd0 && !flag_inexact_o && !flag_underflow_o
         && !flag_overflow_o && !flag_invalid_o));

    assert_nan_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(alt_fmt_i) && $past(src_i[30:23]) == 8'hff
         && $past(src_i[22:0]) != 23'd0) |-> (dst_o[14:9] == 6'h3f));
endmodule

// File: tb/f2h_convert_test.sv
`timescale 1ns/1ps
module f2h_convert_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic [1:0]  rnd_i = '0;
    logic        tin_before_i = 1'b0;
    logic        flush_den_i = 1'b0;
    logic        alt_fmt_i = 1'b0;
    logic [15:0] dst_o;
    logic        flag_inexact_o, flag_underflow_o, flag_overflow_o, flag_invalid_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    f2h_convert uut (
        .clk(clk), .rst(rst), .src_i(src_i), .rnd_i(rnd_i),
        .tin_before_i(tin_before_i), .flush_den_i(flush_den_i),
        .alt_fmt_i(alt_fmt_i), .dst_o(dst_o),
        .flag_inexact_o(flag_inexact_o), .flag_underflow_o(flag_underflow_o),
        .flag_overflow_o(flag_overflow_o), .flag_invalid_o(flag_invalid_o)
    );

    // value-based reference: quotient by the target quantum, then round
    task automatic ref_model(input logic [31:0] op, input logic [1:0] md,
                             input logic tb4, input logic fz, input logic alt,
                             output logic [15:0] r, output logic [3:0] fl,
                             output string tag);
        logic s;
        int ex, es, unb, te, rs, field, maxf;
        longint sig, n, rem, half;
        logic ix, uf, gt, tie, inc;
        s = op[31]; ex = int'(op[30:23]); fl = 4'b0000;
        if (ex == 255) begin
            if (op[22:0] == 0) begin
                tag = alt ? "R13" : "R12";
                if (alt) begin r = {s, 15'h7fff}; fl = 4'b0001; end
                else r = {s, 15'h7c00};
            end else begin
                tag = alt ? "R13" : "R12";
                if (alt) begin r = {s, 15'h0000}; fl = 4'b0001; end
                else begin r = {s, 5'h1f, 1'b1, op[21:13]}; fl = {3'b000, ~op[22]}; end
            end
            return;
        end
        if (ex == 0 && (op[22:0] == 0 || fz)) begin
            tag = (op[22:0] == 0) ? "R11" : "R10";
            r = {s, 15'h0000};
            return;
        end
        sig = (ex == 0) ? longint'(op[22:0]) : longint'(op[22:0]) + (64'd1 << 23);
        es  = (ex == 0) ? 1 : ex;
        unb = es - 127;
        te  = (unb < -14) ? -14 : unb;
        rs  = te + 140 - es;
        if (rs > 40) begin
            n = 0; rem = sig; gt = 1'b0; tie = 1'b0;
        end else begin
            n = sig >> rs; rem = sig - (n << rs); half = 64'd1 << (rs - 1);
            gt = rem > half; tie = rem == half;
        end
        ix = (rem != 0);
        case (md)
            2'd0: inc = gt || (tie && n[0]);
            2'd1: inc = !s && ix;
            2'd2: inc = s && ix;
            default: inc = 1'b0;
        endcase
        n = n + longint'(inc);
        if (n == 2048) begin n = 1024; te = te + 1; end
        field = (n >= 1024) ? te + 15 : 0;
        maxf  = alt ? 31 : 30;
        if (field > maxf) begin
            tag = alt ? "R7" : "R6";
            if (alt) begin r = {s, 15'h7fff}; fl = 4'b0001; end
            else begin r = {s, 15'h7c00}; fl = 4'b1010; end
            return;
        end
        uf = ix && (unb < -14) && (tb4 || field == 0);
        r  = {s, 5'(field), 10'(n)};
        fl = {ix, uf, 2'b00};
        if (ex == 0)         tag = "R10";
        else if (uf)         tag = "R9";
        else if (unb < -14)  tag = "R8";
        else if (!ix)        tag = "R2";
        else if (md == 2'd0) tag = "R3";
        else                 tag = "R4";
    endtask

    task automatic compare(input string tag, input logic [15:0] er, input logic [3:0] ef);
        logic [3:0] af;
        af = {flag_inexact_o, flag_underflow_o, flag_overflow_o, flag_invalid_o};
        checks++;
        if (dst_o !== er || af !== ef) begin
            failures++;
            $display("FAIL %s op=%h mode=%0d tb=%0b fz=%0b alt=%0b: got %h flags %b, expected %h flags %b",
                     tag, src_i, rnd_i, tin_before_i, flush_den_i, alt_fmt_i, dst_o, af, er, ef);
        end
    endtask

    task automatic drive(input logic [31:0] op, input logic [1:0] md,
                         input logic tb4, input logic fz, input logic alt);
        @(negedge clk);
        src_i = op; rnd_i = md; tin_before_i = tb4; flush_den_i = fz; alt_fmt_i = alt;
        @(negedge clk);
    endtask

    task automatic lit(input logic [31:0] op, input logic [1:0] md, input logic tb4,
                       input logic fz, input logic alt, input logic [15:0] er,
                       input logic [3:0] ef, input string tag);
        drive(op, md, tb4, fz, alt);
        compare(tag, er, ef);
    endtask

    task automatic modeled(input logic [31:0] op, input logic [1:0] md, input logic tb4,
                           input logic fz, input logic alt);
        logic [15:0] er; logic [3:0] ef; string tag;
        drive(op, md, tb4, fz, alt);
        ref_model(op, md, tb4, fz, alt, er, ef, tag);
        compare(tag, er, ef);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        src_i = 32'h3f800000;
        repeat (3) @(negedge clk);
        compare("R1", 16'h0000, 4'b0000);          // held in reset
        rst = 1'b0;
        @(posedge clk);
        #1;
        checks++;                                    // R1: value one cycle after edge
        if (dst_o !== 16'h3c00) begin
            failures++;
            $display("FAIL R1 latency: got %h expected %h", dst_o, 16'h3c00);
        end

        // flags order {inexact, underflow, overflow, invalid}
        lit(32'h3f800000, 2'd0, 1'b0, 1'b0, 1'b0, 16'h3c00, 4'b0000, "R2");
        lit(32'h477fe000, 2'd0, 1'b0, 1'b0, 1'b0, 16'h7bff, 4'b0000, "R2");
        lit(32'h3f801000, 2'd0, 1'b0, 1'b0, 1'b0, 16'h3c00, 4'b1000, "R3");
        lit(32'h3f803000, 2'd0, 1'b0, 1'b0, 1'b0, 16'h3c02, 4'b1000, "R3");
        lit(32'hbf800001, 2'd2, 1'b0, 1'b0, 1'b0, 16'hbc01, 4'b1000, "R4");
        lit(32'hbf800001, 2'd1, 1'b0, 1'b0, 1'b0, 16'hbc00, 4'b1000, "R4");
        lit(32'h3f800001, 2'd3, 1'b0, 1'b0, 1'b0, 16'h3c00, 4'b1000, "R4");
        lit(32'h3fffffff, 2'd0, 1'b0, 1'b0, 1'b0, 16'h4000, 4'b1000, "R5");
        lit(32'h477ff000, 2'd0, 1'b0, 1'b0, 1'b0, 16'h7c00, 4'b1010, "R6");
        lit(32'h49742400, 2'd3, 1'b0, 1'b0, 1'b0, 16'h7c00, 4'b1010, "R6");
        lit(32'h47800000, 2'd0, 1'b0, 1'b0, 1'b1, 16'h7c00, 4'b0000, "R7");
        lit(32'h477ff000, 2'd0, 1'b0, 1'b0, 1'b1, 16'h7c00, 4'b1000, "R7");
        lit(32'hc9742400, 2'd0, 1'b0, 1'b0, 1'b1, 16'hffff, 4'b0001, "R7");
        lit(32'h33800000, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0001, 4'b0000, "R8");
        lit(32'h33000000, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 4'b1100, "R8");
        lit(32'h33000000, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0001, 4'b1100, "R8");
        lit(32'h2f000000, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0001, 4'b1100, "R8");
        lit(32'h387fffff, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0400, 4'b1100, "R9");
        lit(32'h387fffff, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0400, 4'b1000, "R9");
        lit(32'h00000001, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0001, 4'b1100, "R10");
        lit(32'h80000001, 2'd0, 1'b0, 1'b1, 1'b0, 16'h8000, 4'b0000, "R10");
        lit(32'h80000000, 2'd1, 1'b0, 1'b0, 1'b0, 16'h8000, 4'b0000, "R11");
        lit(32'hff800000, 2'd0, 1'b0, 1'b0, 1'b0, 16'hfc00, 4'b0000, "R12");
        lit(32'h7fc00000, 2'd0, 1'b0, 1'b0, 1'b0, 16'h7e00, 4'b0000, "R12");
        lit(32'h7f802000, 2'd0, 1'b0, 1'b0, 1'b0, 16'h7e01, 4'b0001, "R12");
        lit(32'hffc00000, 2'd0, 1'b0, 1'b0, 1'b1, 16'h8000, 4'b0001, "R13");
        lit(32'hff800000, 2'd0, 1'b0, 1'b0, 1'b1, 16'hffff, 4'b0001, "R13");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] op;
            op = $urandom;
            if ($urandom_range(9) < 8) op[30:23] = 8'(95 + $urandom_range(51));
            if ($urandom_range(7) == 0) op[12:0] = {1'b1, 12'h000};
            if ($urandom_range(15) == 0) op[30:23] = 8'h00;
            if ($urandom_range(31) == 0) op[30:23] = 8'hff;
            modeled(op, 2'($urandom_range(3)), 1'($urandom_range(1)),
                    1'($urandom_range(1)), 1'($urandom_range(1)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule